// File: doc/BRIEF.md
# Iterative Integer Divider with Exact Flags

This block divides integers sequentially, one quotient bit per clock. It has four operations. A short form divides 32 bits by 16 bits, and a long form divides 64 bits by 32 bits. Each form exists in an unsigned and a two's-complement variant. The caller pulses a start strobe with the operation code, the dividend words, the divisor and two destination register indices. The block strips the operand signs and runs a radix-2 restoring loop. It then restores the signs, decides whether the result fits, and emits register write requests together with N, Z, V and C flags.

The short form returns a single packed word to the quotient register, with the remainder in the upper half. The long form writes the remainder and the quotient to two registers. When both indices are the same register, only the quotient is written. A zero divisor raises a trap strobe and writes nothing. An overflow writes nothing, sets V, clears Z and leaves N as it was. C is always clear. The register file and the trap handler sit outside the block.

Top module: `iter_divider`

## Requirements
- R1: op_i selects the operation: 2'b00 is unsigned 32/16, 2'b01 is signed 32/16, 2'b10 is unsigned 64/32 and 2'b11 is signed 64/32. The short form divides dvd_lo_i by dvs_i[15:0] and ignores dvd_hi_i and dvs_i[31:16]. On success it asserts q_we_o with q_idx_o equal to the captured q_idx_i, and q_data_o[15:0] holds the quotient and q_data_o[31:16] the remainder. It never asserts r_we_o.
- R2: The long form divides the 64-bit value {dvd_hi_i, dvd_lo_i} by dvs_i. On success it writes the 32-bit quotient through the q port and the 32-bit remainder through the r port, at the captured indices.
- R3: A divisor that is zero at the operation's width (the low 16 bits for the short form) pulses dz_trap_o together with done_o on the cycle after start. Neither write enable is asserted, and N, Z and V keep their values.
- R4: Signed division truncates toward zero, and a nonzero remainder carries the sign of the dividend.
- R5: An overflow sets V, clears Z, leaves N unchanged and asserts no write enable. The overflow conditions are:
  - unsigned short form: quotient above 0xFFFF;
  - signed short form: quotient outside -32768..32767;
  - unsigned long form: quotient above 0xFFFFFFFF;
  - signed long form: quotient outside the signed 32-bit range.
- R6: Without overflow, V is cleared, N is the sign bit of the quotient at the operation's width (16 or 32 bits), and Z is set when that quotient is zero.
- R7: flag_c_o is 0 after every operation, including overflow and divide by zero.
- R8: In the long form with r_idx_i equal to q_idx_i, only the quotient write is issued, so that register ends up holding the quotient.
- R9: done_o is a single-cycle pulse. busy_o is high from the cycle after an accepted start until done_o. A start while busy_o is high is ignored and produces no extra done_o.
- R10: After reset, busy_o, done_o, dz_trap_o, q_we_o, r_we_o and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken when not busy |
| op_i | input | 2 | Operation code |
| dvd_hi_i | input | 32 | Upper dividend word (long form only) |
| dvd_lo_i | input | 32 | Lower dividend word, or the whole short-form dividend |
| dvs_i | input | 32 | Divisor (low 16 bits in the short form) |
| q_idx_i | input | 3 | Quotient destination index |
| r_idx_i | input | 3 | Remainder destination index |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | Result strobe |
| dz_trap_o | output | 1 | Divide-by-zero trap strobe |
| q_we_o | output | 1 | Quotient write enable |
| q_idx_o | output | 3 | Quotient write index |
| q_data_o | output | 32 | Quotient word (packed word in the short form) |
| r_we_o | output | 1 | Remainder write enable |
| r_idx_o | output | 3 | Remainder write index |
| r_data_o | output | 32 | Remainder word |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
The bench targets the quotient range edges:
- 0xFFFF unsigned and -32768 signed just fit; a design that checked overflow before sign correction would reject them.
- 32768, and 0x80000000 divided by -1, must overflow; a design that missed these would wrap the quotient into the register.

It runs an overflow right after a negative quotient, so a design that recomputed N on overflow would show it cleared. It applies a short-form divisor whose low half is zero but whose upper half is not, which catches a zero test taken at the full width. It also covers negative divisors with upper junk bits, a shared destination in the long form, and a start pulsed while busy, which would otherwise surface as a second result.

// File: rtl/idiv_pkg.sv
package idiv_pkg;
  typedef enum logic [1:0] {
    OP_W_U = 2'b00,
    OP_W_S = 2'b01,
    OP_L_U = 2'b10,
    OP_L_S = 2'b11
  } div_op_e;
endpackage

// File: rtl/idiv_prep.sv
module idiv_prep #(
  parameter int DW = 32
) (
  input  logic [1:0]      op_i,
  input  logic [DW-1:0]   hi_i,
  input  logic [DW-1:0]   lo_i,
  input  logic [DW-1:0]   dvs_i,
  output logic [2*DW-1:0] acc_o,
  output logic [DW-1:0]   dvs_mag_o,
  output logic            long_o,
  output logic            sgn_o,
  output logic            neg_q_o,
  output logic            neg_r_o,
  output logic            dvs_zero_o
);
  import idiv_pkg::*;
  localparam int HW = DW / 2;
  localparam int AW = 2 * DW;

  div_op_e        op;
  logic           sd, sv;
  logic [DW-1:0]  dvs_w;
  logic [AW-1:0]  dvd_l;

  assign op = div_op_e'(op_i);

  always_comb begin
    long_o = (op == OP_L_U) || (op == OP_L_S);
    sgn_o  = (op == OP_W_S) || (op == OP_L_S);
    sd     = sgn_o & (long_o ? hi_i[DW-1] : lo_i[DW-1]);
    if (long_o)     dvs_w = dvs_i;
    else if (sgn_o) dvs_w = {{HW{dvs_i[HW-1]}}, dvs_i[HW-1:0]};
    else            dvs_w = {{HW{1'b0}}, dvs_i[HW-1:0]};
    sv         = sgn_o & dvs_w[DW-1];
    dvs_mag_o  = sv ? -dvs_w : dvs_w;
    dvs_zero_o = (dvs_w == '0);
    dvd_l      = {hi_i, lo_i};
    // short form pre-aligned so its DW quotient bits land in the low half
    if (long_o) acc_o = sd ? -dvd_l : dvd_l;
    else        acc_o = {(sd ? -lo_i : lo_i), {DW{1'b0}}};
    neg_q_o = sd ^ sv;
    neg_r_o = sd;
  end
endmodule

// File: rtl/idiv_core.sv
module idiv_core #(
  parameter int DW = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [2*DW-1:0] acc_i,
  input  logic [DW-1:0]   dvs_i,
  input  logic            long_i,
  output logic            fin_o,
  output logic [2*DW-1:0] quo_o,
  output logic [DW-1:0]   rem_o
);
  localparam int AW = 2 * DW;
  localparam int CW = $clog2(AW + 1);

  logic [AW-1:0] acc_q;
  logic [DW-1:0] rem_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          fin_q;
  logic [DW:0]   trial, diff;
  logic          take;

  always_comb begin
    trial = {rem_q, acc_q[AW-1]};
    diff  = trial - {1'b0, dvs_q};
    take  = trial >= {1'b0, dvs_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      rem_q <= '0;
      dvs_q <= '0;
      cnt_q <= '0;
      fin_q <= 1'b0;
    end else if (load_i) begin
      acc_q <= acc_i;
      rem_q <= '0;
      dvs_q <= dvs_i;
      cnt_q <= long_i ? CW'(AW) : CW'(DW);
      fin_q <= 1'b0;
    end else if (cnt_q != '0) begin
      acc_q <= {acc_q[AW-2:0], take};
      rem_q <= take ? diff[DW-1:0] : trial[DW-1:0];
      cnt_q <= cnt_q - 1'b1;
      fin_q <= (cnt_q == CW'(1));
    end else begin
      fin_q <= 1'b0;
    end
  end

  assign fin_o = fin_q;
  assign quo_o = acc_q;
  assign rem_o = rem_q;

  // partial remainder stays below the divisor while iterating (R1, R2)
  p_rem_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (rem_q < dvs_q));
  p_fin_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_q |-> (cnt_q == '0));
endmodule

// File: rtl/idiv_post.sv
module idiv_post #(
  parameter int DW = 32
) (
  input  logic            long_i,
  input  logic            sgn_i,
  input  logic            neg_q_i,
  input  logic            neg_r_i,
  input  logic [2*DW-1:0] qmag_i,
  input  logic [DW-1:0]   rmag_i,
  output logic            ovf_o,
  output logic [DW-1:0]   q_word_o,
  output logic [DW-1:0]   r_word_o,
  output logic            n_o,
  output logic            z_o
);
  localparam int HW = DW / 2;
  localparam int AW = 2 * DW;
  localparam logic [AW-1:0] W_U_MAX = {{(AW-HW){1'b0}}, {HW{1'b1}}};
  localparam logic [AW-1:0] W_S_POS = {{(AW-HW+1){1'b0}}, {(HW-1){1'b1}}};
  localparam logic [AW-1:0] W_S_NEG = W_S_POS + 1'b1;
  localparam logic [AW-1:0] L_U_MAX = {{(AW-DW){1'b0}}, {DW{1'b1}}};
  localparam logic [AW-1:0] L_S_POS = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic [AW-1:0] L_S_NEG = L_S_POS + 1'b1;

  logic [HW-1:0] q_w, r_w;
  logic [DW-1:0] q_l, r_l;
  logic [AW-1:0] lim;

  always_comb begin
    q_w = neg_q_i ? -qmag_i[HW-1:0] : qmag_i[HW-1:0];
    r_w = neg_r_i ? -rmag_i[HW-1:0] : rmag_i[HW-1:0];
    q_l = neg_q_i ? -qmag_i[DW-1:0] : qmag_i[DW-1:0];
    r_l = neg_r_i ? -rmag_i : rmag_i;
    // a negative result may reach one magnitude step further
    if (long_i) lim = sgn_i ? (neg_q_i ? L_S_NEG : L_S_POS) : L_U_MAX;
    else        lim = sgn_i ? (neg_q_i ? W_S_NEG : W_S_POS) : W_U_MAX;
    ovf_o = qmag_i > lim;
    if (long_i) begin
      q_word_o = q_l;
      r_word_o = r_l;
      n_o      = q_l[DW-1];
      z_o      = (q_l == '0);
    end else begin
      q_word_o = {r_w, q_w};
      r_word_o = '0;
      n_o      = q_w[HW-1];
      z_o      = (q_w == '0);
    end
  end
endmodule

// File: rtl/iter_divider.sv
module iter_divider #(
  parameter int DW = 32,
  parameter int IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [DW-1:0] dvd_hi_i,
  input  logic [DW-1:0] dvd_lo_i,
  input  logic [DW-1:0] dvs_i,
  input  logic [IW-1:0] q_idx_i,
  input  logic [IW-1:0] r_idx_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          dz_trap_o,
  output logic          q_we_o,
  output logic [IW-1:0] q_idx_o,
  output logic [DW-1:0] q_data_o,
  output logic          r_we_o,
  output logic [IW-1:0] r_idx_o,
  output logic [DW-1:0] r_data_o,
  output logic          flag_n_o,
  output logic          flag_z_o,
  output logic          flag_v_o,
  output logic          flag_c_o
);
  localparam int AW = 2 * DW;

  logic [AW-1:0] acc_init, quo;
  logic [DW-1:0] dvs_mag, rem, q_word, r_word;
  logic          p_long, p_sgn, p_negq, p_negr, p_dz;
  logic          fin, ovf, pn, pz, accept, load;

  logic          busy_q, long_q, sgn_q, negq_q, negr_q;
  logic [IW-1:0] qi_q, ri_q;
  logic          done_q, dz_q, qwe_q, rwe_q, n_q, z_q, v_q;
  logic [IW-1:0] qidx_q, ridx_q;
  logic [DW-1:0] qd_q, rd_q;

  idiv_prep #(.DW(DW)) u_prep (
    .op_i(op_i), .hi_i(dvd_hi_i), .lo_i(dvd_lo_i), .dvs_i(dvs_i),
    .acc_o(acc_init), .dvs_mag_o(dvs_mag), .long_o(p_long), .sgn_o(p_sgn),
    .neg_q_o(p_negq), .neg_r_o(p_negr), .dvs_zero_o(p_dz)
  );

  assign accept = start_i && !busy_q;
  assign load   = accept && !p_dz;

  idiv_core #(.DW(DW)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .acc_i(acc_init),
    .dvs_i(dvs_mag), .long_i(p_long), .fin_o(fin), .quo_o(quo), .rem_o(rem)
  );

  idiv_post #(.DW(DW)) u_post (
    .long_i(long_q), .sgn_i(sgn_q), .neg_q_i(negq_q), .neg_r_i(negr_q),
    .qmag_i(quo), .rmag_i(rem), .ovf_o(ovf), .q_word_o(q_word),
    .r_word_o(r_word), .n_o(pn), .z_o(pz)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; long_q <= 1'b0; sgn_q <= 1'b0;
      negq_q <= 1'b0; negr_q <= 1'b0; qi_q <= '0; ri_q <= '0;
      done_q <= 1'b0; dz_q <= 1'b0; qwe_q <= 1'b0; rwe_q <= 1'b0;
      qidx_q <= '0; ridx_q <= '0; qd_q <= '0; rd_q <= '0;
      n_q <= 1'b0; z_q <= 1'b0; v_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      dz_q   <= 1'b0;
      qwe_q  <= 1'b0;
      rwe_q  <= 1'b0;
      if (accept) begin
        if (p_dz) begin
          done_q <= 1'b1;
          dz_q   <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          long_q <= p_long;
          sgn_q  <= p_sgn;
          negq_q <= p_negq;
          negr_q <= p_negr;
          qi_q   <= q_idx_i;
          ri_q   <= r_idx_i;
        end
      end
      if (fin) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        if (ovf) begin
          v_q <= 1'b1;
          z_q <= 1'b0;
        end else begin
          qwe_q  <= 1'b1;
          qidx_q <= qi_q;
          qd_q   <= q_word;
          // shared destination: the quotient wins
          rwe_q  <= long_q && (ri_q != qi_q);
          ridx_q <= ri_q;
          rd_q   <= r_word;
          n_q    <= pn;
          z_q    <= pz;
          v_q    <= 1'b0;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign dz_trap_o = dz_q;
  assign q_we_o    = qwe_q;
  assign q_idx_o   = qidx_q;
  assign q_data_o  = qd_q;
  assign r_we_o    = rwe_q;
  assign r_idx_o   = ridx_q;
  assign r_data_o  = rd_q;
  assign flag_n_o  = n_q;
  assign flag_z_o  = z_q;
  assign flag_v_o  = v_q;
  assign flag_c_o  = 1'b0;

  p_dz_nowr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dz_trap_o |-> (done_o && !q_we_o && !r_we_o));
  p_ovf_nowr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && flag_v_o && !dz_trap_o) |-> (!q_we_o && !r_we_o && !flag_z_o));
  p_ovf_nkeep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && flag_v_o && !dz_trap_o) |-> (flag_n_o == $past(flag_n_o)));
  p_word_nor_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !long_q) |-> !r_we_o);
  p_same_idx_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_we_o |-> (r_idx_o != q_idx_o));
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_busy_end_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
endmodule

// File: tb/iter_divider_bench.sv
module iter_divider_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit          dz;
    bit          wq;
    logic [2:0]  qi;
    logic [31:0] qd;
    bit          wr;
    logic [2:0]  ri;
    logic [31:0] rd;
    bit          n, z, v;
    string       tag;
  } exp_t;

  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0]  op = '0;
  logic [31:0] hi = '0, lo = '0, dv = '0;
  logic [2:0]  qi = '0, ri = '0;
  logic        busy_o, done_o, dz_o, qwe, rwe, fn, fz, fv, fc;
  logic [2:0]  qidx, ridx;
  logic [31:0] qd, rd;

  int   n_chk = 0, n_fail = 0, done_seen = 0, n_pushed = 0;
  bit   m_n = 0, m_z = 0, m_v = 0, prev_done = 0;
  exp_t q_exp[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  iter_divider u_iter_divider (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .dvd_hi_i(hi), .dvd_lo_i(lo), .dvs_i(dv), .q_idx_i(qi), .r_idx_i(ri),
    .busy_o(busy_o), .done_o(done_o), .dz_trap_o(dz_o),
    .q_we_o(qwe), .q_idx_o(qidx), .q_data_o(qd),
    .r_we_o(rwe), .r_idx_o(ridx), .r_data_o(rd),
    .flag_n_o(fn), .flag_z_o(fz), .flag_v_o(fv), .flag_c_o(fc)
  );

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic model(input logic [1:0] o, input logic [31:0] h, l, d,
                       input logic [2:0] qx, rx, input string tag, output exp_t e);
    bit lng, sg, sd, sv, ng, ovf;
    logic [63:0] am, q, r, qv, rv;
    logic [31:0] dx, bm;
    lng = o[1]; sg = o[0];
    e = '{dz:0, wq:0, qi:qx, qd:0, wr:0, ri:rx, rd:0, n:0, z:0, v:0, tag:tag};
    sd = sg & (lng ? h[31] : l[31]);
    am = lng ? {h, l} : {32'b0, l};
    if (sd) am = lng ? -am : {32'b0, -l};
    dx = lng ? d : (sg ? {{16{d[15]}}, d[15:0]} : {16'b0, d[15:0]});
    sv = sg & dx[31];
    bm = sv ? -dx : dx;
    if (bm == 0) begin
      e.dz = 1;
    end else begin
      q = am / {32'b0, bm};
      r = am % {32'b0, bm};
      ng = sd ^ sv;
      if (!lng) ovf = sg ? (ng ? q > 64'd32768 : q > 64'd32767) : q > 64'hFFFF;
      else      ovf = sg ? (ng ? q > 64'h80000000 : q > 64'h7FFFFFFF) : q > 64'hFFFFFFFF;
      if (ovf) begin
        m_v = 1; m_z = 0;
      end else begin
        qv = ng ? -q : q;
        rv = sd ? -r : r;
        e.wq = 1;
        m_v = 0;
        if (!lng) begin
          e.qd = {rv[15:0], qv[15:0]};
          m_n = qv[15]; m_z = (qv[15:0] == 0);
        end else begin
          e.qd = qv[31:0];
          e.wr = (rx != qx);
          e.rd = rv[31:0];
          m_n = qv[31]; m_z = (qv[31:0] == 0);
        end
      end
    end
    e.n = m_n; e.z = m_z; e.v = m_v;
  endtask

  task automatic pulse(input logic [1:0] o, input logic [31:0] h, l, d, input logic [2:0] qx, rx);
    op = o; hi = h; lo = l; dv = d; qi = qx; ri = rx; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic run_op(input logic [1:0] o, input logic [31:0] h, l, d,
                        input logic [2:0] qx, rx, input string tag);
    exp_t e;
    model(o, h, l, d, qx, rx, tag, e);
    q_exp.push_back(e);
    n_pushed++;
    pulse(o, h, l, d, qx, rx);
    if (!e.dz) chk(busy_o === 1'b1, {tag, " R9 busy after start"}, busy_o, 1);
    wait (done_seen == n_pushed);
    @(posedge clk); #1;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        exp_t e;
        done_seen++;
        chk(!prev_done, "R9 done single pulse", prev_done, 0);
        if (q_exp.size() == 0) begin
          chk(0, "R9 unexpected done", 1, 0);
        end else begin
          e = q_exp.pop_front();
          chk(dz_o == e.dz, {e.tag, " R3 trap"}, dz_o, e.dz);
          chk(qwe == e.wq, {e.tag, " q write enable"}, qwe, e.wq);
          if (e.wq) begin
            chk(qidx == e.qi, {e.tag, " q index"}, qidx, e.qi);
            chk(qd == e.qd, {e.tag, " q data"}, qd, e.qd);
          end
          chk(rwe == e.wr, {e.tag, " r write enable"}, rwe, e.wr);
          if (e.wr) begin
            chk(ridx == e.ri, {e.tag, " r index"}, ridx, e.ri);
            chk(rd == e.rd, {e.tag, " r data"}, rd, e.rd);
          end
          chk(fn == e.n, {e.tag, " N flag"}, fn, e.n);
          chk(fz == e.z, {e.tag, " Z flag"}, fz, e.z);
          chk(fv == e.v, {e.tag, " V flag"}, fv, e.v);
          chk(fc == 1'b0, {e.tag, " R7 carry"}, fc, 0);
        end
      end
      prev_done = done_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(busy_o == 0 && done_o == 0 && dz_o == 0, "R10 reset strobes", {busy_o, done_o, dz_o}, 0);
    chk(qwe == 0 && rwe == 0, "R10 reset write enables", {qwe, rwe}, 0);
    chk({fn, fz, fv, fc} == 4'b0, "R10 reset flags", {fn, fz, fv, fc}, 0);
    @(posedge clk); #1;

    run_op(2'b00, 32'hDEAD_0000, 32'd100000, 32'd7, 3'd1, 3'd0, "R1 word unsigned");
    run_op(2'b00, 32'h0, 32'd3, 32'h1234_0005, 3'd2, 3'd0, "R6 zero quotient");
    run_op(2'b00, 32'h0, 32'h0001_FFFE, 32'd2, 3'd3, 3'd0, "R5 R6 word unsigned max fits");
    run_op(2'b00, 32'h0, 32'h0010_0000, 32'd1, 3'd3, 3'd0, "R5 word unsigned overflow keeps N");
    run_op(2'b01, 32'h0, 32'hFFFF_FFF9, 32'h0000_0002, 3'd4, 3'd0, "R4 signed neg dividend");
    run_op(2'b01, 32'h0, 32'd7, 32'hABCD_FFFE, 3'd5, 3'd0, "R4 signed neg divisor");
    run_op(2'b01, 32'h0, 32'hFFFF_8000, 32'd1, 3'd6, 3'd0, "R5 word signed min fits");
    run_op(2'b01, 32'h0, 32'h0000_8000, 32'd1, 3'd6, 3'd0, "R5 word signed plus overflow");
    run_op(2'b01, 32'h0, 32'h8000_0000, 32'h0000_FFFF, 3'd6, 3'd0, "R5 word signed min by minus one");
    run_op(2'b00, 32'h0, 32'd50, 32'h0001_0000, 3'd1, 3'd0, "R3 word zero low half");
    run_op(2'b10, 32'h1, 32'h0, 32'd2, 3'd2, 3'd3, "R2 long unsigned");
    run_op(2'b10, 32'h5, 32'h0, 32'd5, 3'd2, 3'd3, "R5 long unsigned overflow");
    run_op(2'b10, 32'h0, 32'd100, 32'd7, 3'd2, 3'd3, "R2 long unsigned small");
    run_op(2'b11, 32'hFFFF_FFFF, 32'hFFFF_FF9C, 32'd7, 3'd0, 3'd7, "R4 long signed");
    run_op(2'b11, 32'h0, 32'h8000_0000, 32'd1, 3'd0, 3'd7, "R5 long signed plus overflow");
    run_op(2'b11, 32'hFFFF_FFFF, 32'h8000_0000, 32'd1, 3'd0, 3'd7, "R5 long signed min fits");
    run_op(2'b11, 32'h8000_0000, 32'h0, 32'hFFFF_FFFF, 3'd0, 3'd7, "R5 long signed min by minus one");
    run_op(2'b10, 32'h0, 32'd50, 32'd8, 3'd4, 3'd4, "R8 shared destination");
    run_op(2'b11, 32'h1234, 32'h5678, 32'h0, 3'd1, 3'd2, "R3 long zero divisor");

    // R9 second start while busy must be ignored
    begin
      exp_t e;
      model(2'b10, 32'h0, 32'd1000, 32'd10, 3'd5, 3'd6, "R9 first of overlapping starts", e);
      q_exp.push_back(e);
      n_pushed++;
      pulse(2'b10, 32'h0, 32'd1000, 32'd10, 3'd5, 3'd6);
      pulse(2'b00, 32'h0, 32'd9, 32'h0, 3'd1, 3'd1);
      wait (done_seen == n_pushed);
      repeat (8) @(posedge clk);
      #1 chk(done_seen == n_pushed, "R9 start while busy ignored", done_seen, n_pushed);
    end
    chk(q_exp.size() == 0, "R9 all results seen", q_exp.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule